// File: doc/BRIEF.md
# CAN Interrupt Status Aggregator

This block sits between a CAN controller and the interrupt logic. It turns per-slot completion pulses and three kinds of error pulses into three separate request lines: one for transmit completion, one for receive completion and one for errors. Each event sets a status bit that stays set until software clears it. A mask bit per status bit decides whether the event may raise a request.

Each request line is a latched flag. A qualifying event sets it, and the matching acknowledge input clears it. Slot requests and the error request react differently to repeated events. Any new enabled slot completion raises its line again, even if older slot status bits are still set. A new error raises the error line only when no enabled error status bit was already set.

Software reaches the block through a small write port. Two addresses hold the masks. Two more clear status bits: writing 1 to a bit clears it.

Top module: `can_irq_aggr`

## Requirements
- R1: A slot completion pulse on `slot_done_i[k]` sets `slot_sts_o[k]` at the next clock edge. The bit stays 1 through acknowledges until software clears it.
- R2: An enabled slot completion with `slot_dir_i[k]`=1 (transmit) sets `irq_o[0]` at the next edge. One with `slot_dir_i[k]`=0 (receive) sets `irq_o[1]` at the next edge.
- R3: A slot whose mask bit is 0 still sets its status bit but raises no request.
- R4: A new enabled slot completion raises its request line even while earlier slot status bits are still 1.
- R5: Error pulses set `err_sts_o` bits: bit 0 is bus error, bit 1 is error-passive entry and bit 2 is bus-off entry. `irq_o[2]` is set at the edge where the OR of the error status bits ANDed with the error mask goes from 0 to 1. This includes the case where a status bit that is already set gets unmasked.
- R6: While any enabled error status bit is 1, a further error event does not set `irq_o[2]`. Masked status bits do not block it.
- R7: The write port decodes `wr_addr_i` as follows: 0 clears slot status bits where the data is 1, 1 loads the slot mask, 2 clears error status bits where data[2:0] is 1, 3 loads the error mask from data[2:0]. Data bits that are 0 leave status unchanged.
- R8: When a completion or error pulse and a software clear hit the same status bit in the same cycle, the bit ends at 1.
- R9: Each `irq_o[i]` holds until `ack_i[i]` is 1 at a clock edge. An acknowledge clears only its own line. A new set in the same cycle as an acknowledge wins.
- R10: Reset (`rst_n`=0) clears all status, mask and request bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_done_i | input | NSLOT | Per-slot completion pulse |
| slot_dir_i | input | NSLOT | Per-slot direction flag, 1 = transmit, 0 = receive |
| err_bus_i | input | 1 | Bus error detected pulse |
| err_passive_i | input | 1 | Error-passive entry pulse |
| err_busoff_i | input | 1 | Bus-off entry pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | NSLOT | Write data |
| ack_i | input | 3 | Per-line request acknowledge |
| irq_o | output | 3 | Latched requests: [0] transmit, [1] receive, [2] error |
| slot_sts_o | output | NSLOT | Slot status bits |
| err_sts_o | output | 3 | Error status bits |

## Verification
The bench targets the asymmetry between slot and error re-triggering. A design that blocked slot requests while old slot status is still set would stay silent after the re-trigger. A design that did not block error requests would raise the error line on the second fault. The bench also leaves a masked error status set and checks that it does not suppress a later enabled error. It checks that a clear and a set in the same cycle leave the bit at 1; a design that let the clear win would lose an event. It checks that an acknowledge in the same cycle as a new event leaves the line high; a design that let the acknowledge win would drop the request. Finally, it unmasks a pending error and expects a request, and it resets the block and shows that a completion no longer raises a request because the masks were cleared.

// File: rtl/can_irq_aggr.sv
module can_irq_aggr #(
  parameter int NSLOT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_done_i,
  input  logic [NSLOT-1:0] slot_dir_i,
  input  logic             err_bus_i,
  input  logic             err_passive_i,
  input  logic             err_busoff_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [NSLOT-1:0] wr_data_i,
  input  logic [2:0]       ack_i,
  output logic [2:0]       irq_o,
  output logic [NSLOT-1:0] slot_sts_o,
  output logic [2:0]       err_sts_o
);
  localparam int NERR = 3;

  logic [NSLOT-1:0] slot_sts_q, slot_mask_q, slot_clr, slot_sts_d, slot_mask_d;
  logic [NERR-1:0]  err_sts_q, err_mask_q, err_clr, err_sts_d, err_mask_d, err_evt;
  logic [2:0]       irq_q, irq_set;
  logic             err_any_q, err_any_d;

  assign slot_clr    = (wr_en_i && wr_addr_i == 2'd0) ? wr_data_i : '0;
  assign slot_mask_d = (wr_en_i && wr_addr_i == 2'd1) ? wr_data_i : slot_mask_q;
  assign err_clr     = (wr_en_i && wr_addr_i == 2'd2) ? wr_data_i[NERR-1:0] : '0;
  assign err_mask_d  = (wr_en_i && wr_addr_i == 2'd3) ? wr_data_i[NERR-1:0] : err_mask_q;

  assign err_evt    = {err_busoff_i, err_passive_i, err_bus_i};
  assign slot_sts_d = (slot_sts_q & ~slot_clr) | slot_done_i;
  assign err_sts_d  = (err_sts_q & ~err_clr) | err_evt;

  assign err_any_q = |(err_sts_q & err_mask_q);
  assign err_any_d = |(err_sts_d & err_mask_d);

  assign irq_set[0] = |(slot_done_i & slot_dir_i & slot_mask_q);
  assign irq_set[1] = |(slot_done_i & ~slot_dir_i & slot_mask_q);
  assign irq_set[2] = err_any_d & ~err_any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_sts_q  <= '0;
      slot_mask_q <= '0;
      err_sts_q   <= '0;
      err_mask_q  <= '0;
      irq_q       <= '0;
    end else begin
      slot_sts_q  <= slot_sts_d;
      slot_mask_q <= slot_mask_d;
      err_sts_q   <= err_sts_d;
      err_mask_q  <= err_mask_d;
      irq_q       <= irq_set | (irq_q & ~ack_i);
    end
  end

  assign irq_o      = irq_q;
  assign slot_sts_o = slot_sts_q;
  assign err_sts_o  = err_sts_q;
endmodule

module can_irq_aggr_chk #(
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] slot_done_i,
  input logic [NSLOT-1:0] slot_dir_i,
  input logic [2:0]       ack_i,
  input logic [2:0]       irq_o,
  input logic [NSLOT-1:0] slot_sts_o,
  input logic [2:0]       err_sts_o,
  input logic [NSLOT-1:0] slot_mask_q,
  input logic [2:0]       err_mask_q
);
  p_sticky_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_done_i) |=> ((slot_sts_o & $past(slot_done_i)) == $past(slot_done_i)));

  p_tx_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(|(slot_done_i & slot_dir_i & slot_mask_q)));

  p_rx_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[1]) |-> $past(|(slot_done_i & ~slot_dir_i & slot_mask_q)));

  p_err_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_sts_o & err_mask_q)) |=> !$rose(irq_o[2]));

  p_hold_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[0] && !ack_i[0]) |=> irq_o[0]);

  p_hold_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[1] && !ack_i[1]) |=> irq_o[1]);

  p_hold_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[2] && !ack_i[2]) |=> irq_o[2]);
endmodule

bind can_irq_aggr can_irq_aggr_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_done_i(slot_done_i), .slot_dir_i(slot_dir_i),
  .ack_i(ack_i), .irq_o(irq_o), .slot_sts_o(slot_sts_o), .err_sts_o(err_sts_o),
  .slot_mask_q(slot_mask_q), .err_mask_q(err_mask_q)
);

// File: tb/can_irq_aggr_tb.sv
module can_irq_aggr_tb;
  localparam int NSLOT = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSLOT-1:0] slot_done = '0, slot_dir = '0, wr_data = '0;
  logic             e_bus = 1'b0, e_pas = 1'b0, e_off = 1'b0, wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [2:0]       ack = '0;
  logic [2:0]       irq, err_sts;
  logic [NSLOT-1:0] slot_sts;
  int               n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  can_irq_aggr #(.NSLOT(NSLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_done_i(slot_done), .slot_dir_i(slot_dir),
    .err_bus_i(e_bus), .err_passive_i(e_pas), .err_busoff_i(e_off),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
    .irq_o(irq), .slot_sts_o(slot_sts), .err_sts_o(err_sts)
  );

  // bits [11:8] slot, [7] dir, [6] done, [5:3] err {off,pas,bus}, [2:0] expected irq
  localparam logic [11:0] VEC [8] = '{
    {4'd3,  1'b1, 1'b1, 3'b000, 3'b001},
    {4'd3,  1'b0, 1'b1, 3'b000, 3'b010},
    {4'd10, 1'b1, 1'b1, 3'b000, 3'b000},
    {4'd0,  1'b0, 1'b0, 3'b001, 3'b100},
    {4'd0,  1'b0, 1'b0, 3'b010, 3'b000},
    {4'd0,  1'b0, 1'b0, 3'b100, 3'b100},
    {4'd7,  1'b0, 1'b1, 3'b010, 3'b010},
    {4'd0,  1'b0, 1'b0, 3'b000, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    slot_done = '0; slot_dir = '0; e_bus = 0; e_pas = 0; e_off = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0; ack = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [NSLOT-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk); #1;
    chk("R10 reset irq", irq, 3'b000);
    chk("R10 reset slot status", slot_sts, '0);
    chk("R10 reset err status", err_sts, 3'b000);
    rst_n = 1;
    wr(2'd1, 16'h00FF); tick();
    wr(2'd3, 16'h0005); tick();

    for (int i = 0; i < 8; i++) begin
      slot_done = VEC[i][6] ? (16'd1 << VEC[i][11:8]) : '0;
      slot_dir  = VEC[i][7] ? (16'd1 << VEC[i][11:8]) : '0;
      {e_off, e_pas, e_bus} = VEC[i][5:3];
      tick();
      chk("R2/R3/R5 table irq", irq, VEC[i][2:0]);
      chk("R1 table slot status", slot_sts, VEC[i][6] ? (16'd1 << VEC[i][11:8]) : 16'd0);
      chk("R5 table err status", err_sts, VEC[i][5:3]);
      ack = 3'b111; wr(2'd0, 16'hFFFF); tick();
      wr(2'd2, 16'h0007); tick();
    end

    slot_done = 16'h0006; slot_dir = 16'h0004; tick();
    chk("R2 tx+rx together", irq, 3'b011);
    ack = 3'b001; tick();
    chk("R9 ack clears own line only", irq, 3'b010);
    chk("R1 status survives ack", slot_sts, 16'h0006);
    ack = 3'b010; tick();
    chk("R9 ack rx", irq, 3'b000);

    slot_done = 16'h0004; slot_dir = 16'h0004; tick();
    chk("R4 retrigger with status set", irq, 3'b001);
    ack = 3'b001; tick();
    slot_done = 16'h0004; slot_dir = 16'h0004; ack = 3'b001; tick();
    chk("R9 set beats ack", irq, 3'b001);
    ack = 3'b111; wr(2'd0, 16'hFFFF); tick();
    chk("R7 clear all slot status", slot_sts, 16'h0000);

    slot_done = 16'h0003; tick();
    wr(2'd0, 16'h0001); tick();
    chk("R7 partial W1C", slot_sts, 16'h0002);
    slot_done = 16'h0002; wr(2'd0, 16'h0002); tick();
    chk("R8 set beats clear", slot_sts, 16'h0002);
    wr(2'd0, 16'h0002); ack = 3'b111; tick();
    chk("R7 clear after race", slot_sts, 16'h0000);

    e_bus = 1; tick();
    chk("R5 bus error request", irq, 3'b100);
    ack = 3'b100; tick();
    chk("R9 err ack", irq, 3'b000);
    e_off = 1; tick();
    chk("R6 blocked by enabled status", irq, 3'b000);
    chk("R5 status both set", err_sts, 3'b101);
    wr(2'd2, 16'h0001); tick();
    chk("R6 still blocked after partial clear", irq, 3'b000);
    chk("R7 err partial W1C", err_sts, 3'b100);
    wr(2'd2, 16'h0004); tick();
    e_off = 1; tick();
    chk("R6 unblocked after clear", irq, 3'b100);
    ack = 3'b111; wr(2'd2, 16'h0007); tick();

    e_pas = 1; tick();
    chk("R3 masked error no request", irq, 3'b000);
    e_bus = 1; tick();
    chk("R6 masked status does not block", irq, 3'b100);
    ack = 3'b111; wr(2'd2, 16'h0001); tick();
    chk("R5 passive status kept", err_sts, 3'b010);
    wr(2'd3, 16'h0007); tick();
    chk("R5 unmask pending raises", irq, 3'b100);
    ack = 3'b111; wr(2'd2, 16'h0007); tick();

    slot_done = 16'h0001; slot_dir = 16'h0001; tick();
    chk("R2 tx before reset", irq, 3'b001);
    rst_n = 0; #2;
    chk("R10 async reset irq", irq, 3'b000);
    chk("R10 async reset status", slot_sts, 16'h0000);
    tick(); rst_n = 1;
    slot_done = 16'h0001; slot_dir = 16'h0001; tick();
    chk("R10 masks cleared by reset", irq, 3'b000);
    chk("R1 status after reset event", slot_sts, 16'h0001);

    finish_run();
  end
endmodule